// File: doc/BRIEF.md
# Line-Locked CPU Clock Divider

This block derives a processor clock from a fast master clock by dividing it by a fixed ratio. Every 65th processor cycle is made two master clocks longer, so that one group of 65 cycles lasts exactly one horizontal video line. With a 14.31818 MHz master clock, a normal cycle is 14 master clocks long (about 978 ns, 1.023 MHz). The stretched cycle is 16 master clocks long (about 1117 ns). A full line is therefore 64×14+16 = 912 master clocks, and the average processor rate is about 1.020 MHz. The processor only sees a slightly longer clock period once per line and needs no knowledge of the stretch.

Each cycle begins with a low phase of 7 master clocks, followed by a high phase. The high phase is 7 master clocks in a normal cycle and 9 in the stretched cycle. The block also outputs the index of the current cycle within the line (0 to 64, where 64 is the stretched cycle) and a one-master-clock strobe that marks the start of cycle 0. It has no data stream, so all pins are plain control signals. Reset is synchronous and active high.

Top module: `line_locked_clkdiv`

## Requirements
- R1: While reset is held, `cycle_idx` is 0, `cpu_clk` is low and `line_strobe` is high; the first master clock after release is phase 0 of cycle 0.
- R2: Cycles 0 to 63 last 14 master clocks each: `cpu_clk` is low for 7 of them, then high for 7.
- R3: Cycle 64 lasts 16 master clocks: `cpu_clk` is low for 7 of them, then high for 9.
- R4: `cycle_idx` changes only at a cycle start, which is the master clock in which `cpu_clk` falls. It steps up by one and wraps from 64 to 0.
- R5: `line_strobe` is high for exactly one master clock, and only in phase 0 of cycle 0. At that time `cpu_clk` is low.
- R6: From one `line_strobe` to the next is 912 master clocks, and this interval contains 65 rising edges of `cpu_clk`.
- R7: `cpu_clk` rises exactly 7 master clocks after every cycle start, in both normal and stretched cycles.
- R8: Asserting reset partway through a line restarts the sequence at cycle 0 with the clock low, as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_clk | output | 1 | Derived processor clock, registered |
| line_strobe | output | 1 | One-master-clock pulse at the start of cycle 0 |
| cycle_idx | output | 7 | Index of the current cycle within the line, 0 to 64 |

## Verification
Every output is registered from the next-state values of the counters. After the Nth rising edge following reset release, the outputs therefore reflect master-clock position N modulo 912, with no extra latency. The bench keeps a count of rising edges since release and samples the outputs on the falling edge after the intended edge. The vector table is indexed by this edge count, and the expected values follow directly from the position arithmetic. The directed tests step one master clock at a time and measure phase lengths and line length from the pins alone.

// File: rtl/line_locked_clkdiv_pkg.sv
package line_locked_clkdiv_pkg;
  // Which half of a processor cycle a master-clock slot belongs to.
  typedef enum logic {
    SEG_LOW  = 1'b0,
    SEG_HIGH = 1'b1
  } seg_e;
endpackage

// File: rtl/llc_phase_timer.sv
// Counts master clocks inside one processor cycle. Normal length is BASE_LEN.
// While the stretched cycle is running, the length grows by EXTRA_LEN.
module llc_phase_timer #(
  parameter int BASE_LEN  = 14,
  parameter int EXTRA_LEN = 2,
  localparam int LONG_LEN = BASE_LEN + EXTRA_LEN,
  localparam int PH_W     = $clog2(LONG_LEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            long_cycle,
  output logic [PH_W-1:0] phase_nxt,
  output logic            cycle_end
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] last_slot;

  always_comb begin
    last_slot = long_cycle ? PH_W'(LONG_LEN - 1) : PH_W'(BASE_LEN - 1);
    cycle_end = (phase_q == last_slot);
    phase_nxt = cycle_end ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_nxt;
  end
endmodule

// File: rtl/llc_cycle_tracker.sv
// Tracks which processor cycle of the line is running and flags the stretched one.
module llc_cycle_tracker #(
  parameter int CYCLES     = 65,
  localparam int IDX_W     = $clog2(CYCLES),
  localparam int LAST      = CYCLES - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] idx_nxt,
  output logic             is_last
);
  always_comb begin
    is_last = (idx == IDX_W'(LAST));
    if (!advance)     idx_nxt = idx;
    else if (is_last) idx_nxt = '0;
    else              idx_nxt = idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) idx <= '0;
    else     idx <= idx_nxt;
  end
endmodule

// File: rtl/llc_clk_shaper.sv
// Registers the processor clock and line strobe from next-state counter values.
// This keeps them aligned with the counters and free of glitches.
module llc_clk_shaper
  import line_locked_clkdiv_pkg::*;
#(
  parameter int PH_W    = 4,
  parameter int IDX_W   = 7,
  parameter int LOW_LEN = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  phase_nxt,
  input  logic [IDX_W-1:0] idx_nxt,
  output logic             cpu_clk,
  output logic             line_strobe
);
  seg_e seg_nxt;
  logic strobe_nxt;

  always_comb begin
    seg_nxt    = (phase_nxt >= PH_W'(LOW_LEN)) ? SEG_HIGH : SEG_LOW;
    strobe_nxt = (phase_nxt == '0) && (idx_nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk     <= 1'b0;
      line_strobe <= 1'b1;
    end else begin
      cpu_clk     <= (seg_nxt == SEG_HIGH);
      line_strobe <= strobe_nxt;
    end
  end
endmodule

// File: rtl/line_locked_clkdiv.sv
module line_locked_clkdiv #(
  parameter int BASE_LEN  = 14,
  parameter int EXTRA_LEN = 2,
  parameter int CYCLES    = 65,
  localparam int LONG_LEN = BASE_LEN + EXTRA_LEN,
  localparam int PH_W     = $clog2(LONG_LEN),
  localparam int IDX_W    = $clog2(CYCLES),
  localparam int LOW_LEN  = BASE_LEN / 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic             cpu_clk,
  output logic             line_strobe,
  output logic [IDX_W-1:0] cycle_idx
);
  logic [PH_W-1:0]  phase_nxt;
  logic             cycle_end;
  logic             is_last;
  logic [IDX_W-1:0] idx_nxt;

  llc_phase_timer #(.BASE_LEN(BASE_LEN), .EXTRA_LEN(EXTRA_LEN)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .long_cycle (is_last),
    .phase_nxt  (phase_nxt),
    .cycle_end  (cycle_end)
  );

  llc_cycle_tracker #(.CYCLES(CYCLES)) u_cyc (
    .clk     (clk),
    .rst     (rst),
    .advance (cycle_end),
    .idx     (cycle_idx),
    .idx_nxt (idx_nxt),
    .is_last (is_last)
  );

  llc_clk_shaper #(.PH_W(PH_W), .IDX_W(IDX_W), .LOW_LEN(LOW_LEN)) u_shape (
    .clk         (clk),
    .rst         (rst),
    .phase_nxt   (phase_nxt),
    .idx_nxt     (idx_nxt),
    .cpu_clk     (cpu_clk),
    .line_strobe (line_strobe)
  );
endmodule

// File: rtl/line_locked_clkdiv_chk.sv
module line_locked_clkdiv_chk #(
  parameter int IDX_W     = 7,
  parameter int CYCLES    = 65,
  parameter int BASE_LEN  = 14,
  parameter int EXTRA_LEN = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_clk,
  input logic             line_strobe,
  input logic [IDX_W-1:0] cycle_idx
);
  localparam int LOW_LEN   = BASE_LEN / 2;
  localparam int HIGH_NORM = BASE_LEN - LOW_LEN;
  localparam int HIGH_LONG = HIGH_NORM + EXTRA_LEN;

  logic [7:0] hi_cnt;
  logic [7:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= cpu_clk ? hi_cnt + 1'b1 : 8'd0;
      lo_cnt <= cpu_clk ? 8'd0 : lo_cnt + 1'b1;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (cycle_idx == '0 && !cpu_clk && line_strobe));

  a_r4_idx_step: assert property (@(posedge clk) disable iff (rst)
    (cycle_idx != $past(cycle_idx)) |->
      ((cycle_idx == $past(cycle_idx) + 1'b1) ||
       ($past(cycle_idx) == IDX_W'(CYCLES - 1) && cycle_idx == '0)));

  a_r4_idx_at_fall: assert property (@(posedge clk) disable iff (rst)
    (cycle_idx != $past(cycle_idx)) |-> (!cpu_clk && $past(cpu_clk)));

  a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
    line_strobe |=> !line_strobe);

  a_r5_strobe_where: assert property (@(posedge clk) disable iff (rst)
    line_strobe |-> (cycle_idx == '0 && !cpu_clk));

  a_r7_low_len: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk && !$past(cpu_clk)) |-> (lo_cnt == 8'(LOW_LEN)));

  a_r2_high_len: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk && $past(cpu_clk) && cycle_idx != '0) |-> (hi_cnt == 8'(HIGH_NORM)));

  a_r3_long_high_len: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk && $past(cpu_clk) && cycle_idx == '0) |-> (hi_cnt == 8'(HIGH_LONG)));
endmodule

bind line_locked_clkdiv line_locked_clkdiv_chk #(
  .IDX_W(IDX_W), .CYCLES(CYCLES), .BASE_LEN(BASE_LEN), .EXTRA_LEN(EXTRA_LEN)
) u_chk (
  .clk(clk), .rst(rst), .cpu_clk(cpu_clk), .line_strobe(line_strobe), .cycle_idx(cycle_idx)
);

// File: tb/sim_line_locked_clkdiv.sv
`timescale 1ns/1ps
module sim_line_locked_clkdiv;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_clk;
  logic       line_strobe;
  logic [6:0] cycle_idx;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  int wd     = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  line_locked_clkdiv u0 (
    .clk(clk), .rst(rst), .cpu_clk(cpu_clk),
    .line_strobe(line_strobe), .cycle_idx(cycle_idx)
  );

  // Edge count after release, expected idx, cpu_clk, strobe.
  localparam int NV = 14;
  localparam int VEC [NV][4] = '{
    '{0,    0,  0, 1}, '{6,    0,  0, 0}, '{7,    0,  1, 0}, '{13,   0,  1, 0},
    '{14,   1,  0, 0}, '{21,   1,  1, 0}, '{895,  63, 1, 0}, '{896,  64, 0, 0},
    '{903,  64, 1, 0}, '{911,  64, 1, 0}, '{912,  0,  0, 1}, '{913,  0,  0, 0},
    '{1824, 0,  0, 1}, '{1929, 7,  1, 0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    edges++;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      finish_run();
    end
  end

  initial begin
    int len, rises, hrun, lrun;
    bit prev;
    repeat (3) @(negedge clk);
    check("R1 idx", int'(cycle_idx), 0);
    check("R1 clk", int'(cpu_clk), 0);
    check("R1 strobe", int'(line_strobe), 1);
    rst = 1'b0;
    edges = 0;
    for (int i = 0; i < NV; i++) begin
      while (edges < VEC[i][0]) step();
      check($sformatf("R2/R3/R4 idx at %0d", VEC[i][0]), int'(cycle_idx), VEC[i][1]);
      check($sformatf("R2/R3/R7 clk at %0d", VEC[i][0]), int'(cpu_clk), VEC[i][2]);
      check($sformatf("R5 strobe at %0d", VEC[i][0]), int'(line_strobe), VEC[i][3]);
    end

    // Measure one full line from strobe to strobe, pin by pin.
    while (!line_strobe) step();
    len = 0; rises = 0; hrun = 0; lrun = 0;
    prev = cpu_clk;
    do begin
      if (cpu_clk) hrun++; else lrun++;
      step();
      len++;
      if (cpu_clk && !prev) begin
        rises++;
        check("R7 low phase length", lrun, 7);
        lrun = 0;
      end
      if (!cpu_clk && prev) begin
        if (cycle_idx == 7'd0) check("R3 stretched high length", hrun, 9);
        else                   check("R2 normal high length", hrun, 7);
        hrun = 0;
      end
      if (line_strobe) check("R5 strobe only at cycle 0", int'(cycle_idx), 0);
      prev = cpu_clk;
    end while (!line_strobe && len < 2000);
    check("R6 line length", len, 912);
    check("R6 rises per line", rises, 65);

    // Reset partway through a line.
    while (cycle_idx != 7'd30 || !cpu_clk) step();
    rst = 1'b1;
    step();
    step();
    check("R8 idx in reset", int'(cycle_idx), 0);
    check("R8 clk in reset", int'(cpu_clk), 0);
    check("R8 strobe in reset", int'(line_strobe), 1);
    rst = 1'b0;
    repeat (6) step();
    check("R8 clk still low", int'(cpu_clk), 0);
    step();
    check("R8 clk rises after 7", int'(cpu_clk), 1);
    repeat (7) step();
    check("R8 next cycle", int'(cycle_idx), 1);
    check("R8 strobe quiet", int'(line_strobe), 0);
    finish_run();
  end
endmodule